// File: doc/BRIEF.md
# Event-Reloaded Watchdog Countdown Timer

This block is a watchdog that counts down from an 8-bit reload value. A one-second tick input paces it. A unit bit selects the step size: one second per step, or one minute per step through an internal divide-by-60 prescaler. A zero reload value turns the countdown off. Any non-zero reload value written by the host loads the counter at once and starts it. When the count reaches zero, the counter stops there and sets a timeout status flag. The interrupt request output follows that flag whenever interrupt routing is enabled.

Three system-event pulses can each be allowed to restart the countdown: a keyboard interrupt, a mouse interrupt and a joystick-port access. An allowed event reloads the counter from the stored value and clears the flag. If no event is allowed, the timer will always time out in the end. The host reaches the block through a small write port and a combinational read port. Through them it can set or clear the flag directly. It can also force an immediate timeout with a control bit that clears itself.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the reload value is 0, the unit is seconds, every event enable is 0, routing is off, the status flag is 0 and `irq_o` is 0. All four registers read back as 0x00.
- R2: While the reload value is 0x00, no number of ticks sets the status flag.
- R3: A write of a non-zero value N to address 0 loads the counter. In seconds mode, the status flag (address 3, bit 0) reads 1 right after the N-th later tick and 0 before it.
- R4: When the count reaches zero it stays there. If the host then clears the flag, further ticks do not set it again until the counter is reloaded.
- R5: Address 1, bit 0 = 1 selects minutes. The counter then steps once every 60 ticks, so the flag sets on tick 60·N and not on tick 60·N−1.
- R6: Address 2, bits 0, 1 and 2 enable `sys_evt_i` bits 0 (keyboard), 1 (mouse) and 2 (joystick). An enabled event pulse reloads the counter from the stored value, clears the flag and restarts the minute prescaler.
- R7: An event pulse whose enable bit is 0 has no effect on the count or on the flag.
- R8: A write to address 3 with bit 2 = 0 sets the flag to the value of data bit 0. This works whatever the counter is doing.
- R9: A write to address 3 with bit 2 = 1 forces the count to zero and sets the flag. Bit 2 always reads back as 0.
- R10: With address 2, bit 3 = 1, `irq_o` equals the flag. With that bit 0, `irq_o` is 0, and the flag still updates.
- R11: If an enabled event and the last countdown step fall in the same cycle, the event wins: the counter reloads and the flag stays 0.
- R12: Address 0 reads back the reload value, address 1 reads back the unit in bit 0, and address 2 reads back the enables in bits 2:0 and the routing bit in bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address (0 reload, 1 unit, 2 config, 3 control) |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data, combinational from the address |
| sys_evt_i | input | 3 | Event pulses: bit 0 keyboard, bit 1 mouse, bit 2 joystick |
| irq_o | output | 1 | Interrupt request following the status flag |

## Verification
All state changes register on the clock edge that samples the strobe. The edge that takes a write, a tick or an event pulse therefore updates the read data and `irq_o` in that same cycle, and they are valid at the following falling edge. The bench drives every input on a falling edge and holds it for exactly one cycle. Each stimulus task returns on the falling edge after the capturing rising edge, and the checks sample there. Minute-mode results are due on tick 60·N. The bench steps to tick 60·N−1, checks that the flag is still 0, and then applies one more tick.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
    typedef enum logic [1:0] {
        REG_RELOAD = 2'd0,
        REG_UNIT   = 2'd1,
        REG_CFG    = 2'd2,
        REG_CTRL   = 2'd3
    } reg_addr_e;

    localparam int CTRL_STATUS_BIT = 0;
    localparam int CTRL_FORCE_BIT  = 2;
    localparam int UNIT_MIN_BIT    = 0;
endpackage

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NUM_EVT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] reload_o,
    output logic              unit_min_o,
    output logic [NUM_EVT-1:0] evt_en_o,
    output logic              route_en_o,
    output logic              reload_wr_o,
    output logic              ctrl_wr_o,
    output logic              ctrl_force_o,
    output logic              ctrl_status_o
);
    typedef struct packed {
        logic [DATA_W-1:0]  reload;
        logic               unit_min;
        logic [NUM_EVT-1:0] evt_en;
        logic               route_en;
    } regs_t;

    regs_t regs_d, regs_q;
    reg_addr_e addr;

    assign addr = reg_addr_e'(wr_addr_i);

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i) begin
            case (addr)
                REG_RELOAD: regs_d.reload   = wr_data_i;
                REG_UNIT:   regs_d.unit_min = wr_data_i[UNIT_MIN_BIT];
                REG_CFG: begin
                    regs_d.evt_en   = wr_data_i[NUM_EVT-1:0];
                    regs_d.route_en = wr_data_i[NUM_EVT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // Strobes to the counter: they act in the cycle of the write
    assign reload_wr_o   = wr_en_i && (addr == REG_RELOAD);
    assign ctrl_wr_o     = wr_en_i && (addr == REG_CTRL);
    assign ctrl_force_o  = ctrl_wr_o && wr_data_i[CTRL_FORCE_BIT];
    assign ctrl_status_o = wr_data_i[CTRL_STATUS_BIT];

    assign reload_o   = regs_q.reload;
    assign unit_min_o = regs_q.unit_min;
    assign evt_en_o   = regs_q.evt_en;
    assign route_en_o = regs_q.route_en;

    logic unused_data;
    assign unused_data = ^wr_data_i;
endmodule

// File: rtl/wdog_prescale.sv
`timescale 1ns/1ps
module wdog_prescale #(
    parameter int DIV = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic minute_i,
    input  logic clear_i,
    output logic step_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;
    logic wrap;

    assign wrap = (pre_q.cnt == LAST);

    always_comb begin
        pre_d = pre_q;
        if (clear_i || !minute_i) begin
            pre_d.cnt = '0;
        end else if (tick_i) begin
            pre_d.cnt = wrap ? '0 : pre_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // One step per tick in seconds mode, one per DIV ticks in minutes mode
    assign step_o = tick_i && !clear_i && (!minute_i || wrap);
endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_i,
    input  logic             wr_load_i,
    input  logic [CNT_W-1:0] wr_val_i,
    input  logic             evt_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             step_i,
    input  logic             ctrl_wr_i,
    input  logic             ctrl_status_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             status_o,
    output logic             load_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             status;
    } cnt_t;

    cnt_t st_d, st_q;
    logic last_step;

    // The step that reaches zero; a reload write or an event in the same cycle cancels it
    assign last_step = step_i && (st_q.cnt == CNT_W'(1)) && !wr_load_i && !evt_i;

    always_comb begin
        st_d = st_q;
        // Count: force > reload write > event > step; a zero count holds (R4)
        if (force_i)                        st_d.cnt = '0;
        else if (wr_load_i)                 st_d.cnt = wr_val_i;
        else if (evt_i)                     st_d.cnt = reload_i;
        else if (step_i && st_q.cnt != '0)  st_d.cnt = st_q.cnt - 1'b1;

        // Status flag: host write > event clear (R11) > terminal set
        if (ctrl_wr_i)      st_d.status = force_i ? 1'b1 : ctrl_status_i;
        else if (evt_i)     st_d.status = 1'b0;
        else if (last_step) st_d.status = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o    = st_q.cnt;
    assign status_o = st_q.status;
    assign load_o   = force_i || wr_load_i || evt_i;
endmodule

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NUM_EVT = 3,
    parameter int DIV     = 60
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [1:0]         rd_addr_i,
    output logic [DATA_W-1:0]  rd_data_o,
    input  logic [NUM_EVT-1:0] sys_evt_i,
    output logic               irq_o
);
    logic [DATA_W-1:0]  reload_val;
    logic               unit_min;
    logic [NUM_EVT-1:0] evt_en;
    logic               route_en;
    logic               reload_wr, ctrl_wr, ctrl_force, ctrl_status;
    logic [DATA_W-1:0]  cnt;
    logic               status;
    logic               load;
    logic               step;
    logic [NUM_EVT-1:0] evt_masked;
    logic               evt_hit;

    wdog_regs #(.DATA_W(DATA_W), .NUM_EVT(NUM_EVT)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .reload_o     (reload_val),
        .unit_min_o   (unit_min),
        .evt_en_o     (evt_en),
        .route_en_o   (route_en),
        .reload_wr_o  (reload_wr),
        .ctrl_wr_o    (ctrl_wr),
        .ctrl_force_o (ctrl_force),
        .ctrl_status_o(ctrl_status)
    );

    // Each event source is gated by its own enable (R6, R7)
    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        assign evt_masked[g] = sys_evt_i[g] & evt_en[g];
    end
    assign evt_hit = |evt_masked;

    wdog_prescale #(.DIV(DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .minute_i(unit_min),
        .clear_i (load),
        .step_o  (step)
    );

    wdog_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .force_i      (ctrl_force),
        .wr_load_i    (reload_wr),
        .wr_val_i     (wr_data_i),
        .evt_i        (evt_hit),
        .reload_i     (reload_val),
        .step_i       (step),
        .ctrl_wr_i    (ctrl_wr),
        .ctrl_status_i(ctrl_status),
        .cnt_o        (cnt),
        .status_o     (status),
        .load_o       (load)
    );

    always_comb begin
        rd_data_o = '0;
        case (reg_addr_e'(rd_addr_i))
            REG_RELOAD: rd_data_o = reload_val;
            REG_UNIT:   rd_data_o[UNIT_MIN_BIT] = unit_min;
            REG_CFG:    rd_data_o[NUM_EVT:0] = {route_en, evt_en};
            REG_CTRL:   rd_data_o[CTRL_STATUS_BIT] = status; // force bit reads 0 (R9)
            default: ;
        endcase
    end

    assign irq_o = route_en & status; // R10
endmodule

// File: rtl/wdog_checker.sv
`timescale 1ns/1ps
module wdog_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [1:0]        wr_addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              evt_hit,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] reload_val,
    input logic              status,
    input logic              route_en,
    input logic              irq_o,
    input logic              load
);
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !route_en |-> !irq_o);

    assert_halt_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !load) |=> cnt == '0);

    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0 && !load) |=> (cnt == $past(cnt) || cnt == DATA_W'($past(cnt) - 1'b1)));

    assert_disabled_no_timeout_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_val == '0 && !wr_en_i) |=> !$rose(status));

    assert_force_timeout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 2'd3 && wr_data_i[2]) |=> (status && cnt == '0));

    assert_event_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_hit && !wr_en_i) |=> (cnt == $past(reload_val) && !status));
endmodule

bind wdog_timer wdog_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .evt_hit   (evt_hit),
    .cnt       (cnt),
    .reload_val(reload_val),
    .status    (status),
    .route_en  (route_en),
    .irq_o     (irq_o),
    .load      (load)
);

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [1:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;
    logic [2:0] sys_evt_i = '0;
    logic       irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    wdog_timer i_wdog_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .sys_evt_i(sys_evt_i), .irq_o(irq_o)
    );

    function automatic bit exp_status(int n, int k);
        return k >= n;
    endfunction

    function automatic bit exp_hit(logic [2:0] ev, logic [2:0] en);
        return (ev & en) != 3'b000;
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk); wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr_i = a; #0.5; d = rd_data_o;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    task automatic evt(input logic [2:0] v, input logic with_tick);
        @(negedge clk); sys_evt_i = v; tick_i = with_tick;
        @(negedge clk); sys_evt_i = '0; tick_i = 1'b0;
    endtask

    task automatic chk_status(input logic exp, input string tag);
        logic [7:0] d;
        rd(2'd3, d);
        chk(d, {7'b0, exp}, tag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d); chk(d, 8'h00, "R1 reset readback");
        end
        chk({7'b0, irq_o}, 8'h00, "R1 irq after reset");

        // R12 readback
        wr(2'd2, 8'h0F); rd(2'd2, d); chk(d, 8'h0F, "R12 config readback");
        wr(2'd1, 8'h01); rd(2'd1, d); chk(d, 8'h01, "R12 unit readback");
        wr(2'd0, 8'h5A); rd(2'd0, d); chk(d, 8'h5A, "R12 reload readback");
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);

        // R2 zero reload disables
        wr(2'd0, 8'h00); wr(2'd3, 8'h00);
        ticks(300); chk_status(1'b0, "R2 disabled no timeout");

        // R3 countdown in seconds
        wr(2'd0, 8'd5);
        ticks(4); chk_status(1'b0, "R3 before terminal");
        ticks(1); chk_status(1'b1, "R3 at terminal");
        chk({7'b0, irq_o}, 8'h00, "R10 irq low when unrouted");

        // R4 halt at zero
        wr(2'd3, 8'h00); ticks(10); chk_status(1'b0, "R4 no wrap after zero");

        // R10 routing
        wr(2'd2, 8'h08); wr(2'd3, 8'h01);
        chk({7'b0, irq_o}, 8'h01, "R10 irq follows status");
        wr(2'd2, 8'h00);
        chk({7'b0, irq_o}, 8'h00, "R10 irq gated off");
        chk_status(1'b1, "R10 status kept while unrouted");

        // R8 direct status write
        wr(2'd3, 8'h00); chk_status(1'b0, "R8 host clear");
        wr(2'd3, 8'h01); chk_status(1'b1, "R8 host set");

        // R9 forced timeout
        wr(2'd0, 8'd10); wr(2'd3, 8'h00);
        wr(2'd3, 8'h04); rd(2'd3, d); chk(d, 8'h01, "R9 force sets status, bit2 reads 0");
        wr(2'd3, 8'h00); ticks(20); chk_status(1'b0, "R9 count forced to zero");

        // R5 minute mode
        wr(2'd1, 8'h01); wr(2'd0, 8'd2);
        ticks(119); chk_status(1'b0, "R5 one tick short");
        ticks(1);   chk_status(1'b1, "R5 at 60*N ticks");

        // R6 enabled event reloads and clears
        wr(2'd1, 8'h00); wr(2'd2, 8'h01); wr(2'd0, 8'd3);
        ticks(3); chk_status(1'b1, "R6 timed out");
        evt(3'b001, 1'b0); chk_status(1'b0, "R6 event clears status");
        ticks(2); chk_status(1'b0, "R6 reload restarted");
        ticks(1); chk_status(1'b1, "R6 reloaded count expires");

        // R6 prescaler restart in minute mode
        wr(2'd1, 8'h01); wr(2'd2, 8'h02); wr(2'd0, 8'd1);
        ticks(30); evt(3'b010, 1'b0);
        ticks(59); chk_status(1'b0, "R6 prescaler restarted");
        ticks(1);  chk_status(1'b1, "R6 minute after event");
        wr(2'd1, 8'h00);

        // R7 disabled events ignored
        wr(2'd2, 8'h01); wr(2'd0, 8'd3); wr(2'd3, 8'h00);
        ticks(2); evt(3'b110, 1'b0);
        ticks(1); chk_status(1'b1, "R7 masked events ignored");

        // R11 event beats terminal step
        wr(2'd0, 8'd3); wr(2'd3, 8'h00);
        ticks(2); evt(3'b001, 1'b1);
        chk_status(1'b0, "R11 event wins over terminal");
        ticks(2); chk_status(1'b0, "R11 reloaded");
        ticks(1); chk_status(1'b1, "R11 expires after reload");

        // Random: R3 countdown, R6/R7 masking
        for (int it = 0; it < 25; it++) begin
            int n, k;
            logic [2:0] en, ev;
            bit hit, st;
            n  = 1 + int'($urandom % 10);
            k  = int'($urandom % (n + 3));
            en = 3'($urandom % 8);
            ev = 3'($urandom % 8);
            wr(2'd2, {5'b0, en}); wr(2'd0, 8'(n)); wr(2'd3, 8'h00);
            ticks(k);
            st = exp_status(n, k);
            chk_status(st, "R3 random countdown");
            hit = exp_hit(ev, en);
            evt(ev, 1'b0);
            chk_status(hit ? 1'b0 : st, hit ? "R6 random event" : "R7 random masked event");
            if (hit) begin
                ticks(n - 1); chk_status(1'b0, "R6 random reload");
                ticks(1);     chk_status(1'b1, "R6 random expiry");
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule